// File: doc/BRIEF.md
# Dual-Display Offset Blur Suppressor

This block stands between a register-write port and the two 64-bit display-position registers of a two-circuit video merge stage. It keeps a mode register and both display registers, and it watches for a blur trick. In that trick both output circuits are on and they show almost the same picture, with the second one shifted by a few pixels. When it sees this, the block drives the first display value onto the second circuit's effective output, so the merged picture comes out sharp.

The decision is combinational on the stored register contents. It therefore follows every write at once: a later write that moves the offsets apart brings back the untouched second value on the next cycle. The stored values are never changed by the override, so reads always return exactly what was written. An `enable` input switches the feature on and off.

Top module: `blur_guard_top`

## Requirements
- R1: After reset, all three stored registers, both effective outputs and every read value are zero.
- R2: A write with `wrAddr` 0 (mode), 1 (display 1) or 2 (display 2) stores `wrData`, and a read with the same code returns it from the next cycle on. Writes to code 3 change nothing, and reads of code 3 return zero.
- R3: `disp1Eff` always equals the stored display 1 value.
- R4: `disp2Eff` equals display 1 when all of these hold. `enable` is high. Mode bits [1:0] are both set. Neither display register is all zero. The absolute difference of the horizontal offsets (bits [11:0]) is at most 6. The absolute difference of the vertical offsets (bits [22:12]) is at most 6. Both offset differences are taken as unsigned field differences.
- R5: An offset difference of 7 or more, in either the horizontal or the vertical field, leaves `disp2Eff` equal to the stored display 2 value.
- R6: If mode bit 0 or mode bit 1 is clear, there is no override.
- R7: If either display register is all zero, there is no override.
- R8: Differences in any bit outside the two offset fields, including the width field (bits [43:32]) and the height field (bits [54:44]), do not prevent the override.
- R9: With `enable` low, `disp2Eff` equals the stored display 2 value. A change of `enable` takes effect with no clock edge.
- R10: While the override is active, a read of display 2 still returns the raw written value.
- R11: The override decision follows the latest stored values from the cycle after each write. Moving the offsets more than 6 apart restores the raw display 2 output at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Enables blur suppression |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register code for writes |
| wrData | input | 64 | Write data |
| rdAddr | input | 2 | Register code for reads |
| rdData | output | 64 | Raw stored value of the selected register |
| disp1Eff | output | 64 | Effective display 1 value |
| disp2Eff | output | 64 | Effective display 2 value, possibly replaced by display 1 |

## Verification
The assertions take for granted that `wrAddr`, `wrEn` and `enable` are known values whenever reset is released. They also take for granted that the write strobe is sampled at the clock edge only. The bench changes every input on the falling edge, so each value is stable and defined across the rising edge. The random stimulus pulls display 2 close to display 1 on most draws, so the threshold compare is hit often on both sides. Directed cases pin the exact 6 and 7 distances, the zero registers and the single-circuit modes.

// File: rtl/blur_guard_pkg.sv
package blur_guard_pkg;
  localparam int NUM_REGS = 3;
  localparam int SEL_MODE = 0;
  localparam int SEL_DISP1 = 1;
  localparam int SEL_DISP2 = 2;

  // Offset fields of a display register
  localparam int HOFS_LSB = 0;
  localparam int HOFS_W = 12;
  localparam int VOFS_LSB = 12;
  localparam int VOFS_W = 11;

  typedef struct packed {
    logic [NUM_REGS-1:0] load;
    logic overrideDisp2;
  } guardStrobes_t;
endpackage

// File: rtl/blur_detect.sv
module blur_detect
  import blur_guard_pkg::*;
#(
  parameter int REG_W = 64,
  parameter int ADDR_W = 2,
  parameter int MAX_SHIFT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        modeBits,
  input  logic [REG_W-1:0]  disp1Raw,
  input  logic [REG_W-1:0]  disp2Raw,
  output guardStrobes_t     strobes
);
  localparam logic [HOFS_W-1:0] H_LIMIT = HOFS_W'(MAX_SHIFT);
  localparam logic [VOFS_W-1:0] V_LIMIT = VOFS_W'(MAX_SHIFT);

  function automatic logic [HOFS_W-1:0] hDist(input logic [HOFS_W-1:0] a, input logic [HOFS_W-1:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  function automatic logic [VOFS_W-1:0] vDist(input logic [VOFS_W-1:0] a, input logic [VOFS_W-1:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  logic [HOFS_W-1:0] hGap;
  logic [VOFS_W-1:0] vGap;
  logic bothCircuits;
  logic bothNonZero;
  logic closeShift;

  always_comb begin
    hGap = hDist(disp1Raw[HOFS_LSB +: HOFS_W], disp2Raw[HOFS_LSB +: HOFS_W]);
    vGap = vDist(disp1Raw[VOFS_LSB +: VOFS_W], disp2Raw[VOFS_LSB +: VOFS_W]);
    bothCircuits = modeBits[0] & modeBits[1];
    bothNonZero = (|disp1Raw) & (|disp2Raw);
    closeShift = (hGap <= H_LIMIT) && (vGap <= V_LIMIT);
  end

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      strobes.load[i] = wrEn && (wrAddr == ADDR_W'(i));
    end
    strobes.overrideDisp2 = enable && bothCircuits && bothNonZero && closeShift;
  end

  // R2
  one_load_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(strobes.load));
  // R6
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.overrideDisp2 |-> (modeBits == 2'b11));
  // R7
  nonzero_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.overrideDisp2 |-> ((disp1Raw != '0) && (disp2Raw != '0)));
  // R9
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !strobes.overrideDisp2);
endmodule

// File: rtl/blur_disp_path.sv
module blur_disp_path
  import blur_guard_pkg::*;
#(
  parameter int REG_W = 64,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  guardStrobes_t     strobes,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  output logic [1:0]        modeBits,
  output logic [REG_W-1:0]  disp1Raw,
  output logic [REG_W-1:0]  disp2Raw,
  output logic [REG_W-1:0]  disp1Eff,
  output logic [REG_W-1:0]  disp2Eff
);
  logic [REG_W-1:0] rawArr [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [REG_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN) q <= '0;
      else if (strobes.load[g]) q <= wrData;
    end
    assign rawArr[g] = q;
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rdAddr == ADDR_W'(i)) rdData = rawArr[i];
    end
  end

  assign modeBits = rawArr[SEL_MODE][1:0];
  assign disp1Raw = rawArr[SEL_DISP1];
  assign disp2Raw = rawArr[SEL_DISP2];
  assign disp1Eff = disp1Raw;
  assign disp2Eff = strobes.overrideDisp2 ? disp1Raw : disp2Raw;

  // R2
  store_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load[SEL_DISP2] |=> (disp2Raw == $past(wrData)));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load == '0) |=> ($stable(disp1Raw) && $stable(disp2Raw)));
  // R4
  mirror_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.overrideDisp2 |-> (disp2Eff == disp1Eff));
  // R3
  disp1_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load[SEL_DISP1] |=> (disp1Eff == $past(wrData)));
endmodule

// File: rtl/blur_guard_top.sv
module blur_guard_top
  import blur_guard_pkg::*;
#(
  parameter int REG_W = 64,
  parameter int ADDR_W = 2,
  parameter int MAX_SHIFT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  output logic [REG_W-1:0]  disp1Eff,
  output logic [REG_W-1:0]  disp2Eff
);
  guardStrobes_t strobes;
  logic [1:0] modeBits;
  logic [REG_W-1:0] disp1Raw;
  logic [REG_W-1:0] disp2Raw;

  blur_detect #(.REG_W(REG_W), .ADDR_W(ADDR_W), .MAX_SHIFT(MAX_SHIFT)) i_detect (
    .clk(clk), .rstN(rstN), .enable(enable), .wrEn(wrEn), .wrAddr(wrAddr),
    .modeBits(modeBits), .disp1Raw(disp1Raw), .disp2Raw(disp2Raw), .strobes(strobes)
  );

  blur_disp_path #(.REG_W(REG_W), .ADDR_W(ADDR_W)) i_path (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .modeBits(modeBits), .disp1Raw(disp1Raw), .disp2Raw(disp2Raw),
    .disp1Eff(disp1Eff), .disp2Eff(disp2Eff)
  );
endmodule

// File: tb/test_blur_guard_top.sv
`timescale 1ns/1ps
module test_blur_guard_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [63:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [63:0] rdData, disp1Eff, disp2Eff;

  int checks = 0;
  int fails = 0;
  logic [63:0] mMode = '0, mD1 = '0, mD2 = '0;

  always #2.5 clk = ~clk;

  blur_guard_top i_blur_guard_top (
    .clk(clk), .rstN(rstN), .enable(enable), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .disp1Eff(disp1Eff), .disp2Eff(disp2Eff)
  );

  function automatic int absDiff(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  function automatic logic [63:0] expD2(input logic en, input logic [63:0] m,
                                        input logic [63:0] a, input logic [63:0] b);
    logic hit;
    hit = en && m[0] && m[1] && (a != 0) && (b != 0) &&
          absDiff(int'(a[11:0]), int'(b[11:0])) <= 6 &&
          absDiff(int'(a[22:12]), int'(b[22:12])) <= 6;
    return hit ? a : b;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (a == 2'd0) mMode = d;
    if (a == 2'd1) mD1 = d;
    if (a == 2'd2) mD2 = d;
  endtask

  task automatic checkOuts(input string req);
    #1;
    check({req, " disp1Eff"}, disp1Eff, mD1);
    check({req, " disp2Eff"}, disp2Eff, expD2(enable, mMode, mD1, mD2));
  endtask

  function automatic logic [63:0] mk(input int hx, input int vy, input logic [31:0] hi);
    logic [63:0] v;
    v = '0;
    v[11:0] = 12'(hx);
    v[22:12] = 11'(vy);
    v[63:32] = hi;
    return v;
  endfunction

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    logic [63:0] base;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 3; a++) begin
      rdAddr = 2'(a); #1;
      check("R1 read", rdData, 64'd0);
    end
    check("R1 disp1Eff", disp1Eff, 64'd0);
    check("R1 disp2Eff", disp2Eff, 64'd0);

    enable = 1'b1;
    wr(2'd0, 64'h3);
    base = mk(100, 50, 32'h0012_3456);
    wr(2'd1, base);
    // R4 exact 6 on both fields
    wr(2'd2, mk(106, 44, 32'h0012_3456));
    checkOuts("R4");
    check("R4 mirrored", disp2Eff, base);
    // R10 raw readback during override
    rdAddr = 2'd2; #1;
    check("R10 raw read", rdData, mk(106, 44, 32'h0012_3456));
    // R8 width/height/magnification differ
    wr(2'd2, mk(97, 53, 32'h0555_0AAA) | 64'h1F80_0000);
    checkOuts("R8");
    check("R8 mirrored", disp2Eff, base);
    // R5 and R11 horizontal 7 restores raw at once
    wr(2'd2, mk(107, 50, 32'h0012_3456));
    checkOuts("R5 h");
    check("R11 restore", disp2Eff, mk(107, 50, 32'h0012_3456));
    // R5 vertical 7
    wr(2'd2, mk(100, 43, 32'h0));
    checkOuts("R5 v");
    // R9 enable off then on, no clock needed
    wr(2'd2, mk(101, 51, 32'h0));
    enable = 1'b0; #1;
    check("R9 off", disp2Eff, mk(101, 51, 32'h0));
    enable = 1'b1; #1;
    check("R9 on", disp2Eff, base);
    // R6 single circuit modes
    wr(2'd0, 64'h1);
    checkOuts("R6 m1");
    check("R6 m1 raw", disp2Eff, mk(101, 51, 32'h0));
    wr(2'd0, 64'h2);
    checkOuts("R6 m2");
    wr(2'd0, 64'h3);
    // R7 zero registers
    wr(2'd1, 64'd0);
    wr(2'd2, 64'd0);
    wr(2'd1, mk(0, 0, 32'h0) | 64'h1_0000_0000);
    checkOuts("R7 d2 zero");
    check("R7 d2 zero raw", disp2Eff, 64'd0);
    wr(2'd2, 64'h2_0000_0000);
    wr(2'd1, 64'd0);
    checkOuts("R7 d1 zero");
    check("R7 d1 zero raw", disp2Eff, 64'h2_0000_0000);
    // R2 code 3 ignored
    wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    rdAddr = 2'd3; #1;
    check("R2 code3 read", rdData, 64'd0);
    checkOuts("R2 code3 write");
    // random mix; R2 R3 R4 R5 R11
    for (int n = 0; n < 400; n++) begin
      int sel;
      sel = $urandom_range(0, 9);
      enable = ($urandom_range(0, 9) != 0);
      if (sel == 0) wr(2'd0, {$urandom, $urandom});
      else if (sel < 4) wr(2'd1, {$urandom, $urandom});
      else if (sel < 9)
        wr(2'd2, mk(int'(mD1[11:0]) + $urandom_range(0, 16) - 8,
                    int'(mD1[22:12]) + $urandom_range(0, 16) - 8, $urandom));
      else wr(2'($urandom_range(0, 3)), {$urandom, $urandom});
      checkOuts("R4 random");
      for (int a = 0; a < 3; a++) begin
        rdAddr = 2'(a); #0.1;
        check("R2 read", rdData, (a == 0) ? mMode : (a == 1) ? mD1 : mD2);
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule